// File: doc/BRIEF.md
# Short-Loop Sequencer with Pipeline Abort

This block is the loop part of a program sequencer for a three-stage fetch, decode and execute pipeline. It produces the address fetched in each cycle. While it is idle, it steps linearly through program memory. A loop command names a first address, a last address and an iteration count. The sequencer then jumps to the first address and repeats the body. It wraps from the last address back to the first with no bubble, and decrements its iteration counter on every wrap.

The decision to leave the loop is made at the fetch of the last body address. That decision may only use an instruction that is already in the execute stage, which is two fetch slots behind. When the loop runs for three or more body fetches in total, that instruction belongs to the loop and the exit costs nothing. When the whole loop is only one or two fetches long, the sequencer has already wrapped before the test can succeed. In that case it flushes the two wrongly fetched slots, which then leave the pipe as NOPs, and resumes at the address after the body.

Loop commands arrive on a valid/ready channel. `loop_ready` is high only while no loop runs and no flush is pending. A command transfers on a cycle where `loop_valid` and `loop_ready` are both high. While `loop_valid` is high and `loop_ready` is low, the requester must hold the command fields stable, and the sequencer ignores them. The caller guarantees that the last address is not below the first.

Top module: `short_loop_seq`

## Requirements
- R1: During and right after reset, `fetch_pc` equals RESET_PC (default 0), `loop_active` is 0, `loop_ready` is 1, `abort_mask` is 0 and `exec_valid` is 0.
- R2: With no loop running and no command transferring, `fetch_pc` advances by exactly 1 each cycle.
- R3: A command transfers when `loop_valid` and `loop_ready` are both high. In the next cycle `fetch_pc` equals the command's first address and `loop_active` is 1. `loop_ready` stays 0 until the loop has fully ended.
- R4: Fetching the last body address with iterations left makes the next fetch the first body address, with no gap. Each such wrap uses up one iteration.
- R5: An iteration count of 0 behaves exactly like a count of 1.
- R6: Exit is granted at the fetch of the final last-address only if the execute stage at that moment holds a valid instruction fetched after the command transferred. The next fetch is then last address + 1, `loop_active` drops, and no cycle is lost.
- R7: If body length times iterations is 1 or 2, the loop wraps anyway. Two cycles after the final last-address fetch, `abort_mask` is asserted, the next fetch is last address + 1, and `loop_active` drops. The executed stream shows exactly two NOPs between the final body instruction and last address + 1.
- R8: `abort_mask` bit 0 kills the slot in fetch and bit 1 kills the slot in decode. The two bits are always asserted together, for one cycle, and only while a loop is active.
- R9: `exec_pc` is the address fetched two cycles earlier. `exec_valid` is 0 for a slot that was aborted, so it is 0 in the cycle after an abort.
- R10: For body length times iterations of 3 or more, the executed stream is the body repeated for the count, followed directly by last address + 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| loop_valid | input | 1 | Loop command offered |
| loop_ready | output | 1 | Sequencer can take a command |
| loop_start_addr | input | ADDR_W | First body address |
| loop_end_addr | input | ADDR_W | Last body address |
| loop_count | input | CNT_W | Iterations (0 means 1) |
| fetch_pc | output | ADDR_W | Address fetched this cycle |
| abort_mask | output | LEAD | Kill bits: bit 0 fetch slot, bit 1 decode slot |
| loop_active | output | 1 | A loop or its flush is in progress |
| exec_pc | output | ADDR_W | Address of the instruction in execute |
| exec_valid | output | 1 | Execute slot holds a real instruction (0 = NOP) |

## Verification
The bench runs every body length from 1 to 3 against iteration counts from 0 to 4. It compares the executed stream cycle by cycle, which separates the three short cases that must flush from the neighbouring cases that must exit for free. A count of 0 is set against a count of 1 to show that the two are the same. Random loops with longer bodies, random first addresses and random idle gaps show that the wrap point, the exit address and the idle stepping follow the command fields, and that no state carries over between back-to-back loops.

// File: rtl/short_loop_seq_pkg.sv
package short_loop_seq_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_RUN   = 2'd1,
    SQ_FLUSH = 2'd2
  } sq_state_e;
endpackage

// File: rtl/short_loop_seq_ctrl.sv
module short_loop_seq_ctrl
  import short_loop_seq_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int LEAD  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [CNT_W-1:0] cmd_count,
  input  logic             pc_at_end,
  input  logic             armed,
  output sq_state_e        state,
  output logic             exit_now,
  output logic             abort_now,
  output logic             wrap_now
);
  localparam int DW = (LEAD > 1) ? $clog2(LEAD) : 1;

  logic [CNT_W-1:0] iter_q;
  logic [DW-1:0]    drain_q;
  logic             last_iter;
  logic             overrun;

  always_comb begin
    last_iter = (iter_q == CNT_W'(1));
    exit_now  = (state == SQ_RUN) && pc_at_end && last_iter && armed;
    overrun   = (state == SQ_RUN) && pc_at_end && last_iter && !armed;
    abort_now = (state == SQ_FLUSH) && (drain_q == '0);
    wrap_now  = ((state == SQ_RUN) && pc_at_end && !exit_now) ||
                ((state == SQ_FLUSH) && pc_at_end && !abort_now);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SQ_IDLE;
      iter_q  <= '0;
      drain_q <= '0;
    end else begin
      case (state)
        SQ_IDLE: begin
          if (accept) begin
            iter_q <= (cmd_count == '0) ? CNT_W'(1) : cmd_count;
            state  <= SQ_RUN;
          end
        end
        SQ_RUN: begin
          if (exit_now) begin
            state <= SQ_IDLE;
          end else if (overrun) begin
            state   <= SQ_FLUSH;
            drain_q <= DW'(LEAD - 1);
          end else if (pc_at_end) begin
            iter_q <= iter_q - CNT_W'(1);
          end
        end
        SQ_FLUSH: begin
          if (abort_now) state <= SQ_IDLE;
          else           drain_q <= drain_q - DW'(1);
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/short_loop_seq_fetch.sv
module short_loop_seq_fetch #(
  parameter int              ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] cmd_start,
  input  logic [ADDR_W-1:0] cmd_end,
  input  logic              do_wrap,
  input  logic              do_exit,
  output logic [ADDR_W-1:0] fetch_pc,
  output logic              pc_is_end
);
  logic [ADDR_W-1:0] first_q;
  logic [ADDR_W-1:0] last_q;
  logic [ADDR_W-1:0] next_pc;

  assign pc_is_end = (fetch_pc == last_q);

  always_comb begin
    if (accept)       next_pc = cmd_start;
    else if (do_exit) next_pc = last_q + ADDR_W'(1);
    else if (do_wrap) next_pc = first_q;
    else              next_pc = fetch_pc + ADDR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_pc <= RESET_PC;
      first_q  <= '0;
      last_q   <= '0;
    end else begin
      fetch_pc <= next_pc;
      if (accept) begin
        first_q <= cmd_start;
        last_q  <= cmd_end;
      end
    end
  end
endmodule

// File: rtl/short_loop_seq_pipe.sv
module short_loop_seq_pipe #(
  parameter int ADDR_W = 16,
  parameter int LEAD   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] fetch_pc,
  input  logic              fetch_in_loop,
  input  logic              clear_tags,
  input  logic              abort_now,
  output logic [ADDR_W-1:0] exec_pc,
  output logic              exec_valid,
  output logic              armed,
  output logic [LEAD-1:0]   abort_mask
);
  logic [LEAD:1][ADDR_W-1:0] pc_q;
  logic [LEAD:1]             vld_q;
  logic [LEAD:1]             tag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q[1]  <= '0;
      vld_q[1] <= 1'b0;
      tag_q[1] <= 1'b0;
    end else begin
      pc_q[1]  <= fetch_pc;
      vld_q[1] <= !abort_now;
      tag_q[1] <= fetch_in_loop && !clear_tags;
    end
  end

  for (genvar k = 2; k <= LEAD; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pc_q[k]  <= '0;
        vld_q[k] <= 1'b0;
        tag_q[k] <= 1'b0;
      end else begin
        pc_q[k]  <= pc_q[k-1];
        vld_q[k] <= vld_q[k-1] && !abort_now;
        tag_q[k] <= tag_q[k-1] && !clear_tags;
      end
    end
  end

  assign exec_pc    = pc_q[LEAD];
  assign exec_valid = vld_q[LEAD];
  assign armed      = vld_q[LEAD] && tag_q[LEAD];
  assign abort_mask = {LEAD{abort_now}};
endmodule

// File: rtl/short_loop_seq.sv
module short_loop_seq
  import short_loop_seq_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter int                CNT_W    = 16,
  parameter int                LEAD     = 2,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loop_valid,
  output logic              loop_ready,
  input  logic [ADDR_W-1:0] loop_start_addr,
  input  logic [ADDR_W-1:0] loop_end_addr,
  input  logic [CNT_W-1:0]  loop_count,
  output logic [ADDR_W-1:0] fetch_pc,
  output logic [LEAD-1:0]   abort_mask,
  output logic              loop_active,
  output logic [ADDR_W-1:0] exec_pc,
  output logic              exec_valid
);
  sq_state_e state;
  logic      accept;
  logic      pc_is_end;
  logic      armed;
  logic      exit_now;
  logic      abort_now;
  logic      wrap_now;

  assign loop_ready  = (state == SQ_IDLE);
  assign loop_active = (state != SQ_IDLE);
  assign accept      = loop_valid && loop_ready;

  short_loop_seq_ctrl #(.CNT_W(CNT_W), .LEAD(LEAD)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .cmd_count (loop_count),
    .pc_at_end (pc_is_end),
    .armed     (armed),
    .state     (state),
    .exit_now  (exit_now),
    .abort_now (abort_now),
    .wrap_now  (wrap_now)
  );

  short_loop_seq_fetch #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) fetch_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .cmd_start (loop_start_addr),
    .cmd_end   (loop_end_addr),
    .do_wrap   (wrap_now),
    .do_exit   (exit_now || abort_now),
    .fetch_pc  (fetch_pc),
    .pc_is_end (pc_is_end)
  );

  short_loop_seq_pipe #(.ADDR_W(ADDR_W), .LEAD(LEAD)) pipe_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .fetch_pc      (fetch_pc),
    .fetch_in_loop (loop_active),
    .clear_tags    (accept),
    .abort_now     (abort_now),
    .exec_pc       (exec_pc),
    .exec_valid    (exec_valid),
    .armed         (armed),
    .abort_mask    (abort_mask)
  );
endmodule

// File: rtl/short_loop_seq_chk.sv
module short_loop_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int LEAD   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              loop_valid,
  input logic              loop_ready,
  input logic [ADDR_W-1:0] loop_start_addr,
  input logic [ADDR_W-1:0] fetch_pc,
  input logic [LEAD-1:0]   abort_mask,
  input logic              loop_active,
  input logic              exec_valid
);
  assert_accept_jump_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_valid && loop_ready) |=> (loop_active && fetch_pc == $past(loop_start_addr)));

  assert_idle_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop_active && !(loop_valid && loop_ready)) |=>
      (fetch_pc == ADDR_W'($past(fetch_pc) + ADDR_W'(1))));

  assert_mask_whole_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_mask == '0) || (abort_mask == '1));

  assert_abort_in_loop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|abort_mask) |-> loop_active);

  assert_abort_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|abort_mask) |=> !loop_active);

  assert_abort_nop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|abort_mask) |=> !exec_valid);
endmodule

bind short_loop_seq short_loop_seq_chk #(.ADDR_W(ADDR_W), .LEAD(LEAD)) chk_i (
  .clk             (clk),
  .rst_n           (rst_n),
  .loop_valid      (loop_valid),
  .loop_ready      (loop_ready),
  .loop_start_addr (loop_start_addr),
  .fetch_pc        (fetch_pc),
  .abort_mask      (abort_mask),
  .loop_active     (loop_active),
  .exec_valid      (exec_valid)
);

// File: tb/short_loop_seq_tb_top.sv
module short_loop_seq_tb_top;
  localparam int ADDR_W = 16;
  localparam int CNT_W  = 16;
  localparam int LEAD   = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              loop_valid = 1'b0;
  logic              loop_ready;
  logic [ADDR_W-1:0] loop_start_addr = '0;
  logic [ADDR_W-1:0] loop_end_addr = '0;
  logic [CNT_W-1:0]  loop_count = '0;
  logic [ADDR_W-1:0] fetch_pc;
  logic [LEAD-1:0]   abort_mask;
  logic              loop_active;
  logic [ADDR_W-1:0] exec_pc;
  logic              exec_valid;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  short_loop_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LEAD(LEAD)) dut_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .loop_valid      (loop_valid),
    .loop_ready      (loop_ready),
    .loop_start_addr (loop_start_addr),
    .loop_end_addr   (loop_end_addr),
    .loop_count      (loop_count),
    .fetch_pc        (fetch_pc),
    .abort_mask      (abort_mask),
    .loop_active     (loop_active),
    .exec_pc         (exec_pc),
    .exec_valid      (exec_valid)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int eff_count(input int n);
    return (n == 0) ? 1 : n;
  endfunction

  function automatic int nop_slots(input int body, input int n);
    return (body * eff_count(n) <= LEAD) ? LEAD : 0;
  endfunction

  // expected executed slot i after loop entry: -1 marks a NOP
  function automatic int exp_slot(input int s, input int body, input int n, input int i);
    int total;
    int nops;
    total = body * eff_count(n);
    nops  = nop_slots(body, n);
    if (i < total) return s + (i % body);
    if (i < total + nops) return -1;
    return s + body + (i - total - nops);
  endfunction

  task automatic run_loop(input int s, input int body, input int n);
    int total;
    int nops;
    string rq;
    total = body * eff_count(n);
    nops  = nop_slots(body, n);
    rq = (nops != 0) ? "R7" : ((n == 0) ? "R5" : "R10");
    @(negedge clk);
    check(loop_ready == 1'b1, "R3", "ready before command", int'(loop_ready), 1);
    loop_valid      = 1'b1;
    loop_start_addr = ADDR_W'(s);
    loop_end_addr   = ADDR_W'(s + body - 1);
    loop_count      = CNT_W'(n);
    @(posedge clk);
    @(negedge clk);
    loop_valid = 1'b0;
    check(fetch_pc == ADDR_W'(s), "R3", "fetch after accept", int'(fetch_pc), s);
    check(loop_active == 1'b1, "R3", "active after accept", int'(loop_active), 1);
    check(loop_ready == 1'b0, "R3", "ready low while busy", int'(loop_ready), 0);
    @(posedge clk);
    for (int i = 0; i < total + nops + 2; i++) begin
      int e;
      @(posedge clk);
      @(negedge clk);
      e = exp_slot(s, body, n, i);
      if (e < 0) begin
        check(exec_valid == 1'b0, "R7", "flushed slot must be NOP", int'(exec_valid), 0);
      end else begin
        check(exec_valid == 1'b1 && exec_pc == ADDR_W'(e),
              (i < total) ? ((i >= body) ? "R4" : rq) : "R6",
              $sformatf("exec slot %0d body=%0d n=%0d", i, body, n),
              exec_valid ? int'(exec_pc) : -1, e);
      end
    end
    check(loop_active == 1'b0 && loop_ready == 1'b1, "R6", "idle after loop",
          int'({loop_active, loop_ready}), 1);
  endtask

  task automatic idle_step(input int gap);
    int prev;
    @(negedge clk);
    prev = int'(fetch_pc);
    for (int g = 0; g <= gap; g++) begin
      @(negedge clk);
      check(fetch_pc == ADDR_W'(prev + 1), "R2", "idle increment", int'(fetch_pc), prev + 1);
      prev = int'(fetch_pc);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++;
        errors++;
        $display("FAIL R1 watchdog: cycles=%0d expected<%0d", cycles, 100000);
        finish_run();
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state while reset is held
    check(fetch_pc == '0, "R1", "reset fetch_pc", int'(fetch_pc), 0);
    check(loop_active == 1'b0, "R1", "reset loop_active", int'(loop_active), 0);
    check(loop_ready == 1'b1, "R1", "reset loop_ready", int'(loop_ready), 1);
    check(abort_mask == '0, "R1", "reset abort_mask", int'(abort_mask), 0);
    check(exec_valid == 1'b0, "R1", "reset exec_valid", int'(exec_valid), 0);
    rst_n = 1'b1;
    idle_step(4);

    // directed corners: body 1..3 with counts 0..4 (0 acts as 1, R5)
    for (int b = 1; b <= 3; b++) begin
      for (int n = 0; n <= 4; n++) begin
        run_loop(100 * b + 10 * n + 16, b, n);
        idle_step(n % 2);
      end
    end

    // back-to-back loops with no idle gap, short then long
    run_loop(500, 1, 1);
    run_loop(600, 1, 1);
    run_loop(700, 3, 2);

    // constrained random loops
    for (int r = 0; r < 40; r++) begin
      int s;
      int b;
      int n;
      s = 16 + int'($urandom % 2000);
      b = 1 + int'($urandom % 6);
      n = int'($urandom % 6);
      run_loop(s, b, n);
      idle_step(int'($urandom % 3));
    end

    finish_run();
  end
endmodule